// File: doc/BRIEF.md
# Backward-Taken Branch Target Predictor

This block predicts the next fetch address for a five-stage 64-bit pipeline. Fetch presents the address of the instruction it is fetching. In the same cycle the block returns whether a branch target is known for that address and which address to fetch next. The static policy is simple: a branch that jumps to a lower address is expected to be taken, and a branch that jumps forward is expected to fall through. Targets come from a small direct-mapped target table. The table only ever holds backward branches, so a table hit is itself the taken prediction.

The execute stage reports each resolved branch to the block. It gives the branch address, the computed target, the prediction that travelled down the pipe with the branch, and the real outcome. From these the block writes new backward targets into the table. It also flags any wrong prediction, together with the address fetch must restart from, so the pipeline can flush the younger instructions. A separate execute-side strobe covers the case where a non-branch instruction hit in the table. That strobe removes the entry and restarts fetch at the following instruction.

Top module: `btfnt_bp`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) invalidates every table entry, so every lookup afterwards misses until new entries are written.
- R2: The table has 32 entries. It is indexed by address bits [6:2] and tagged with bits [63:7]. A lookup whose entry is valid and whose tag matches drives `f_hit` and `f_taken` to 1 and `f_next_pc` to the stored target.
- R3: A lookup that misses drives `f_hit` and `f_taken` to 0 and `f_next_pc` to `f_pc + 4`.
- R4: A resolved, taken branch whose target is below its address (unsigned compare) is written at its index on the clock edge. The write replaces any previous occupant, and the branch hits from the next cycle on.
- R5: A branch whose target is not below its address is never written, so fetch is never steered to a forward target.
- R6: A resolved taken branch raises `x_mispredict` with `x_redirect_pc` equal to the target when it was predicted not taken or when the predicted target differs from the computed one.
- R7: A branch predicted taken that resolves not taken raises `x_mispredict` with `x_redirect_pc = x_pc + 4`, and its table entry is kept.
- R8: A resolved branch whose predicted direction and target match the outcome does not raise `x_mispredict`.
- R9: When a write and a lookup hit the same index in one cycle, the lookup returns the contents from before the write.
- R10: `x_alias` clears the entry at the index of `x_pc` and raises `x_mispredict` with `x_redirect_pc = x_pc + 4`. It takes priority over a branch resolution in the same cycle, which then writes nothing.
- R11: With `x_valid` and `x_alias` both low, `x_mispredict` stays low and the table is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| f_pc | input | 64 | Address being fetched |
| f_hit | output | 1 | Table hit for `f_pc` |
| f_taken | output | 1 | Predicted taken |
| f_next_pc | output | 64 | Predicted next fetch address |
| x_valid | input | 1 | A branch resolves this cycle |
| x_pc | input | 64 | Address of the resolving instruction |
| x_target | input | 64 | Computed branch target |
| x_pred_taken | input | 1 | Direction predicted at fetch |
| x_pred_target | input | 64 | Target predicted at fetch |
| x_taken | input | 1 | Actual branch outcome |
| x_alias | input | 1 | Non-branch hit in the table; invalidate its entry |
| x_mispredict | output | 1 | Flush request |
| x_redirect_pc | output | 64 | Address to restart fetch from |

## Verification
The hardest situation to reach from the ports is a write and a lookup to the same index in one cycle. In that case the lookup must still return the old entry. The bench reaches it by first filling an index and then presenting a fetch address and a fresh allocation for that index together. It samples the fetch outputs before and after the edge. Tag conflicts are reached by sweeping all 32 indices with two address bases that share the index bits but differ in the tag. Forward branches are driven into indices that are already occupied, so that a stray write would show up as a lost entry.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int unsigned XLEN = 64;
  typedef logic [XLEN-1:0] addr_t;

  // Sequential successor of a fetch address.
  function automatic addr_t seq_next(addr_t pc);
    return pc + addr_t'(4);
  endfunction

  // Target strictly below the branch address.
  function automatic logic is_backward(addr_t pc, addr_t tgt);
    return tgt < pc;
  endfunction
endpackage

// File: rtl/bp_btb_store.sv
module bp_btb_store
  import bp_pkg::*;
#(
  parameter int unsigned ENTRIES = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-3:0] rd_word,
  output logic            rd_hit,
  output addr_t           rd_tgt,
  input  logic            wr_en,
  input  logic [XLEN-3:0] wr_word,
  input  addr_t           wr_tgt,
  input  logic            inv_en,
  input  logic [XLEN-3:0] inv_word
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = XLEN - 2 - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(logic [XLEN-3:0] w);
    return w[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [XLEN-3:0] w);
    return w[XLEN-3:IDX_W];
  endfunction

  logic             valid_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  addr_t            tgt_q   [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx, inv_idx;
  assign rd_idx  = idx_of(rd_word);
  assign wr_idx  = idx_of(wr_word);
  assign inv_idx = idx_of(inv_word);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic wr_here, inv_here;
    assign wr_here  = wr_en && (wr_idx == IDX_W'(e));
    assign inv_here = inv_en && (inv_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[e] <= 1'b0;
      end else if (inv_here) begin
        valid_q[e] <= 1'b0;
      end else if (wr_here) begin
        valid_q[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst && !inv_here && wr_here) begin
        tag_q[e] <= tag_of(wr_word);
        tgt_q[e] <= wr_tgt;
      end
    end
  end

  assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == tag_of(rd_word));
  assign rd_tgt = tgt_q[rd_idx];
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve
  import bp_pkg::*;
(
  input  logic  x_valid,
  input  addr_t x_pc,
  input  addr_t x_target,
  input  logic  x_pred_taken,
  input  addr_t x_pred_target,
  input  logic  x_taken,
  input  logic  x_alias,
  output logic  mispredict,
  output addr_t redirect_pc,
  output logic  alloc_en,
  output logic  inv_en
);
  always_comb begin
    mispredict  = 1'b0;
    redirect_pc = seq_next(x_pc);
    alloc_en    = 1'b0;
    inv_en      = 1'b0;
    if (x_alias) begin
      inv_en     = 1'b1;
      mispredict = 1'b1;
    end else if (x_valid) begin
      alloc_en = x_taken && is_backward(x_pc, x_target);
      if (x_taken && (!x_pred_taken || (x_pred_target != x_target))) begin
        mispredict  = 1'b1;
        redirect_pc = x_target;
      end else if (!x_taken && x_pred_taken) begin
        mispredict = 1'b1;
      end
    end
  end
endmodule

// File: rtl/btfnt_bp.sv
module btfnt_bp
  import bp_pkg::*;
#(
  parameter int unsigned ENTRIES = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] f_pc,
  output logic            f_hit,
  output logic            f_taken,
  output logic [XLEN-1:0] f_next_pc,
  input  logic            x_valid,
  input  logic [XLEN-1:0] x_pc,
  input  logic [XLEN-1:0] x_target,
  input  logic            x_pred_taken,
  input  logic [XLEN-1:0] x_pred_target,
  input  logic            x_taken,
  input  logic            x_alias,
  output logic            x_mispredict,
  output logic [XLEN-1:0] x_redirect_pc
);
  logic  alloc_en, inv_en, look_hit;
  addr_t look_tgt;

  bp_resolve u_res (
    .x_valid      (x_valid),
    .x_pc         (x_pc),
    .x_target     (x_target),
    .x_pred_taken (x_pred_taken),
    .x_pred_target(x_pred_target),
    .x_taken      (x_taken),
    .x_alias      (x_alias),
    .mispredict   (x_mispredict),
    .redirect_pc  (x_redirect_pc),
    .alloc_en     (alloc_en),
    .inv_en       (inv_en)
  );

  bp_btb_store #(.ENTRIES(ENTRIES)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .rd_word (f_pc[XLEN-1:2]),
    .rd_hit  (look_hit),
    .rd_tgt  (look_tgt),
    .wr_en   (alloc_en),
    .wr_word (x_pc[XLEN-1:2]),
    .wr_tgt  (x_target),
    .inv_en  (inv_en),
    .inv_word(x_pc[XLEN-1:2])
  );

  assign f_hit     = look_hit;
  assign f_taken   = look_hit;
  assign f_next_pc = look_hit ? look_tgt : seq_next(f_pc);
endmodule

// File: rtl/btfnt_bp_chk.sv
module btfnt_bp_chk
  import bp_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input addr_t f_pc,
  input logic  f_hit,
  input logic  f_taken,
  input addr_t f_next_pc,
  input logic  x_valid,
  input addr_t x_pc,
  input addr_t x_target,
  input logic  x_taken,
  input logic  x_pred_taken,
  input addr_t x_pred_target,
  input logic  x_alias,
  input logic  x_mispredict,
  input addr_t x_redirect_pc,
  input logic  alloc_en,
  input logic  inv_en
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) $past(rst) |-> !f_hit);

  // R3
  miss_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !f_hit |-> (f_next_pc == f_pc + 64'd4) && !f_taken);

  // R5
  only_backward_chk: assert property (@(posedge clk) disable iff (rst)
    f_hit |-> (f_next_pc < f_pc) && f_taken);

  // R4
  alloc_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(alloc_en) && !$past(rst) && (f_pc == $past(x_pc)))
      |-> f_hit && (f_next_pc == $past(x_target)));

  // R5
  alloc_backward_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> (x_target < x_pc) && x_taken);

  // R10
  alias_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(inv_en) && !$past(rst) && (f_pc == $past(x_pc))) |-> !f_hit);

  // R10
  alias_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    x_alias |-> x_mispredict && (x_redirect_pc == x_pc + 64'd4) && !alloc_en);

  // R8
  correct_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (x_valid && !x_alias && (x_pred_taken == x_taken) &&
     (!x_taken || (x_pred_target == x_target))) |-> !x_mispredict);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!x_valid && !x_alias) |-> !x_mispredict && !alloc_en && !inv_en);
endmodule

bind btfnt_bp btfnt_bp_chk u_chk (.*);

// File: tb/tb_btfnt_bp.sv
module tb_btfnt_bp;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] f_pc;
  logic        f_hit, f_taken;
  logic [63:0] f_next_pc;
  logic        x_valid, x_pred_taken, x_taken, x_alias;
  logic [63:0] x_pc, x_target, x_pred_target;
  logic        x_mispredict;
  logic [63:0] x_redirect_pc;

  always #5 clk = ~clk;

  btfnt_bp dut (.*);

  int total = 0;
  int fails = 0;

  // Reference table held by the bench: full branch address and target.
  logic        m_v [32];
  logic [63:0] m_pc[32];
  logic [63:0] m_t [32];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 32; i++) m_v[i] = 1'b0;
  endtask

  function automatic logic exp_hit(input logic [63:0] pc);
    return m_v[pc[6:2]] && (m_pc[pc[6:2]][63:7] == pc[63:7]);
  endfunction

  // Starts and ends one time unit after a rising edge.
  task automatic look(input logic [63:0] pc, input string req);
    logic eh;
    f_pc = pc;
    #1;
    eh = exp_hit(pc);
    check(req, {63'd0, f_hit}, {63'd0, eh});
    check(req, {63'd0, f_taken}, {63'd0, eh});
    check(req, f_next_pc, eh ? m_t[pc[6:2]] : pc + 64'd4);
    @(posedge clk); #1;
  endtask

  task automatic resolve(input logic [63:0] pc, input logic [63:0] tgt,
                         input logic pt, input logic [63:0] ptgt,
                         input logic tk, input logic al, input logic vl,
                         input string req);
    logic        em;
    logic [63:0] er;
    x_valid = vl; x_pc = pc; x_target = tgt; x_pred_taken = pt;
    x_pred_target = ptgt; x_taken = tk; x_alias = al;
    #1;
    em = 1'b0; er = pc + 64'd4;
    if (al) em = 1'b1;
    else if (vl && tk && (!pt || ptgt != tgt)) begin em = 1'b1; er = tgt; end
    else if (vl && !tk && pt) em = 1'b1;
    check(req, {63'd0, x_mispredict}, {63'd0, em});
    if (em) check(req, x_redirect_pc, er);
    @(posedge clk);
    if (al) m_v[pc[6:2]] = 1'b0;
    else if (vl && tk && tgt < pc) begin
      m_v[pc[6:2]] = 1'b1; m_pc[pc[6:2]] = pc; m_t[pc[6:2]] = tgt;
    end
    #1;
    x_valid = 1'b0; x_alias = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [63:0] b, p;
    rst = 1'b1; f_pc = '0; x_valid = 0; x_alias = 0; x_taken = 0;
    x_pred_taken = 0; x_pc = '0; x_target = '0; x_pred_target = '0;
    model_clear();
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;

    // R1 / R3: empty table after reset, every index misses.
    for (int i = 0; i < 32; i++) look(64'h1000 + 64'(i) * 4, "R1_R3");

    // R4 / R6: fill every index with a backward branch, missed then taken.
    b = 64'h8000_0000;
    for (int i = 0; i < 32; i++) begin
      p = b + 64'(i) * 4;
      resolve(p, p - 64'h40 - 64'(i) * 16, 1'b0, '0, 1'b1, 1'b0, 1'b1, "R4_R6");
    end
    // R2: all hit; R3: same index, other tag misses.
    for (int i = 0; i < 32; i++) look(b + 64'(i) * 4, "R2");
    for (int i = 0; i < 32; i++) look(b + 64'h80 + 64'(i) * 4, "R2_R3");

    // R5 / R6: forward taken branches mispredict to target and are not stored.
    for (int i = 0; i < 32; i += 3) begin
      p = 64'h9000_0000 + 64'(i) * 4;
      resolve(p, p + 64'h200, 1'b0, '0, 1'b1, 1'b0, 1'b1, "R5_R6");
      look(p, "R5");
      look(b + 64'(i) * 4, "R5");
    end

    // R8: correct taken prediction; correct not-taken prediction.
    p = b + 64'd8;
    resolve(p, m_t[2], 1'b1, m_t[2], 1'b1, 1'b0, 1'b1, "R8");
    resolve(64'h9000_1000, 64'h9000_2000, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R8");
    // R6: predicted taken but target changed, entry replaced.
    resolve(p, p - 64'h1000, 1'b1, m_t[2], 1'b1, 1'b0, 1'b1, "R6");
    look(p, "R4_R6");
    // R7: predicted taken, resolved not taken; entry remains.
    resolve(p, p - 64'h1000, 1'b1, p - 64'h1000, 1'b0, 1'b0, 1'b1, "R7");
    look(p, "R7");
    // R4: overwrite occupant with a new tag at index 2.
    resolve(p + 64'h80, p - 64'h20, 1'b0, '0, 1'b1, 1'b0, 1'b1, "R4");
    look(p + 64'h80, "R4");
    look(p, "R4");

    // R11: idle execute side leaves everything alone.
    resolve(b + 64'd12, b, 1'b0, '0, 1'b1, 1'b0, 1'b0, "R11");
    look(b + 64'd12, "R11");

    // R10: alias invalidate, alone and together with an allocating branch.
    resolve(b + 64'd16, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R10");
    look(b + 64'd16, "R10");
    resolve(b + 64'd20, b, 1'b0, '0, 1'b1, 1'b1, 1'b1, "R10");
    look(b + 64'd20, "R10");

    // R9: same-cycle lookup and write to index 7.
    p = b + 64'd28;
    f_pc = p;
    x_valid = 1; x_pc = p; x_target = p - 64'h300; x_taken = 1;
    x_pred_taken = 1; x_pred_target = m_t[7]; x_alias = 0;
    #1;
    check("R9", {63'd0, f_hit}, 64'd1);
    check("R9", f_next_pc, m_t[7]);
    @(posedge clk);
    m_t[7] = p - 64'h300;
    #1 x_valid = 0;
    look(p, "R9");

    // R1: reset in the middle of operation empties the table.
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    model_clear();
    for (int i = 0; i < 32; i++) look(b + 64'(i) * 4, "R1");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule